// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block decides, within one clock cycle, which ready instructions leave the scheduler. It looks at five instruction classes: integer, floating point, branch, memory and miscellaneous. Each class has its own ready queue, and each queue shows the selector a small window of its oldest entries in age order. Every window entry carries a valid bit, a sequence number and a squashed flag. The selector fills issue slots one at a time. For each slot it takes the oldest eligible head across all classes. A class is eligible while its queue still has a valid entry in the window and it has not yet reached its own per-class limit. Selection stops once the total issue width is reached or no eligible head is left.

When a head is squashed, it is discarded instead of issued, and selection restarts from the next entry. The selector also tells each queue how many entries to pop from its front, counting both issued and discarded entries. It keeps running counts of issued instructions per class and of discarded squashed entries.

Sequence numbers have a fixed width, so they can wrap. By default, age is compared with modular arithmetic: `a` is older than `b` when the most significant bit of `(a - b) mod 2^SEQW` is set. A parameter switches this to a plain magnitude comparison.

Top module: `issue_selector`

## Requirements
- R1: Each issue slot takes the oldest head among the eligible classes. When two classes present the same sequence number, the lower class code wins.
- R2: No more than TOTAL_W instructions issue in a cycle. The issued instructions fill slots from slot 0 upward with no gaps, and `iss_count` equals the number of valid slots.
- R3: A class issues no more than its own cap in a cycle. Caps by default: integer 2, float 2, branch 1, memory 1, misc 1. When one class reaches its cap, the other classes keep issuing.
- R4: A squashed head of an eligible class is discarded and not issued. It is counted in `q_pop` and in `sqz_drop`, and selection continues past it in the same cycle.
- R5: A squashed entry is left in place, and not counted, if its class has reached its cap or the total width has been reached before the entry becomes the class head.
- R6: When no class has an eligible head, `iss_count` is 0, every `iss_valid` bit is 0 and every `q_pop` is 0. Squashed flags on invalid window entries have no effect.
- R7: With the default wrap-around age compare and SEQW = 8, sequence 250 is older than sequence 3.
- R8: `q_pop[c]` is the number of entries taken from the front of class c's window (issued plus discarded). `cls_issued[c]` is the number of entries of class c that issued this cycle.
- R9: At each rising clock edge, `stat_issued[c]` adds `cls_issued[c]` and `stat_squash` adds `sqz_drop`. Both counters are zero after reset.
- R10: `iss_class` uses these codes: integer 0, float 1, branch 2, memory 3, misc 4.
- R11: Within one cycle, the issued sequence numbers go from oldest in slot 0 to youngest in the highest valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the statistics counters |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_valid | input | NCLS x LOOK | Window entry present, per class and position (position 0 is oldest) |
| hd_squash | input | NCLS x LOOK | Window entry has been squashed |
| hd_seq | input | NCLS x LOOK x SEQW | Sequence number of each window entry |
| iss_valid | output | TOTAL_W | Issue slot holds an instruction |
| iss_class | output | TOTAL_W x 3 | Class code of each issue slot |
| iss_seq | output | TOTAL_W x SEQW | Sequence number of each issue slot |
| iss_count | output | clog2(TOTAL_W+1) | Number of instructions issued this cycle |
| q_pop | output | NCLS x clog2(LOOK+1) | Entries to pop from each class queue |
| cls_issued | output | NCLS x clog2(LOOK+1) | Instructions issued per class this cycle |
| sqz_drop | output | clog2(NCLS*LOOK+1) | Squashed entries discarded this cycle |
| stat_issued | output | NCLS x STW | Running issued count per class |
| stat_squash | output | STW | Running count of discarded squashed entries |

## Verification
The hardest case to reach is a squashed entry that becomes a class head only partway through a cycle. This happens after an older sibling from the same queue has already issued. The entry then has to be discarded in the middle of the slot sequence without leaving a gap in the slots. One directed scenario places a squashed entry behind a ready one in the same window, next to a younger entry in another class. Other scenarios cover the opposite case: a squashed entry sitting behind a class that is already capped, or behind a cycle whose total width is already used up, must stay in the queue. Wrap-around age is tested by placing sequence numbers on both sides of the wrap point.

// File: rtl/iss_pkg.sv
package iss_pkg;
   localparam int unsigned NCLS = 5;
   localparam int unsigned CLW  = 3;

   typedef enum logic [CLW-1:0] {
      CL_INT  = 3'd0,
      CL_FP   = 3'd1,
      CL_BR   = 3'd2,
      CL_MEM  = 3'd3,
      CL_MISC = 3'd4
   } iss_class_e;
endpackage

// File: rtl/iss_oldest.sv
// Parallel oldest-of-N picker over the class heads of one selection step.
module iss_oldest
   import iss_pkg::*;
#(
   parameter int unsigned SEQW     = 8,
   parameter bit          WRAP_AGE = 1'b1
) (
   input  logic [NCLS-1:0]           cand,
   input  logic [NCLS-1:0][SEQW-1:0] seq,
   output logic                      found,
   output logic [CLW-1:0]            win
);
   logic [NCLS-1:0][NCLS-1:0] older;
   logic [NCLS-1:0][NCLS-1:0] beats;
   logic [NCLS-1:0]           win_oh;

   for (genvar a = 0; a < NCLS; a++) begin : g_a
      for (genvar b = 0; b < NCLS; b++) begin : g_b
         if (a == b) begin : g_self
            assign older[a][b] = 1'b0;
            assign beats[a][b] = 1'b1;
         end else begin : g_pair
            if (WRAP_AGE) begin : g_wrap
               logic [SEQW-1:0] diff;
               assign diff        = seq[a] - seq[b];
               assign older[a][b] = diff[SEQW-1];
            end else begin : g_plain
               assign older[a][b] = seq[a] < seq[b];
            end
            // lower class code wins an exact tie
            assign beats[a][b] = !cand[b] || older[a][b] ||
                                 (!older[b][a] && (a < b));
         end
      end
      assign win_oh[a] = cand[a] && (&beats[a]);
   end

   always_comb begin
      win = '0;
      for (int a = 0; a < NCLS; a++) begin
         if (win_oh[a]) win = CLW'(a);
      end
   end

   assign found = |cand;
endmodule

// File: rtl/iss_step.sv
// One selection step: discard squashed eligible heads, or issue the oldest.
module iss_step
   import iss_pkg::*;
#(
   parameter int unsigned           SEQW     = 8,
   parameter int unsigned           LOOK     = 2,
   parameter int unsigned           TOTAL_W  = 4,
   parameter logic [NCLS*8-1:0]     CAPV     = '0,
   parameter bit                    WRAP_AGE = 1'b1,
   parameter int unsigned           PW       = 2,
   parameter int unsigned           CW       = 3
) (
   input  logic [NCLS-1:0][LOOK-1:0]           hd_valid,
   input  logic [NCLS-1:0][LOOK-1:0]           hd_squash,
   input  logic [NCLS-1:0][LOOK-1:0][SEQW-1:0] hd_seq,
   input  logic [NCLS-1:0][PW-1:0]             ptr_i,
   input  logic [NCLS-1:0][PW-1:0]             cnt_i,
   input  logic [CW-1:0]                       tot_i,
   output logic [NCLS-1:0][PW-1:0]             ptr_o,
   output logic [NCLS-1:0][PW-1:0]             cnt_o,
   output logic [CW-1:0]                       tot_o,
   output logic                                fire_o,
   output logic [CLW-1:0]                      cls_o,
   output logic [SEQW-1:0]                     seq_o,
   output logic [NCLS-1:0]                     drop_o
);
   logic [NCLS-1:0]           hv, hq, elig, sqz, cand;
   logic [NCLS-1:0][SEQW-1:0] hseq;
   logic                      found;
   logic [CLW-1:0]            win;

   always_comb begin
      for (int c = 0; c < NCLS; c++) begin
         hv[c]   = 1'b0;
         hq[c]   = 1'b0;
         hseq[c] = '0;
         for (int k = 0; k < LOOK; k++) begin
            if (ptr_i[c] == PW'(k)) begin
               hv[c]   = hd_valid[c][k];
               hq[c]   = hd_squash[c][k];
               hseq[c] = hd_seq[c][k];
            end
         end
         elig[c] = hv[c] && (int'(cnt_i[c]) < int'(CAPV[c*8 +: 8])) &&
                   (int'(tot_i) < int'(TOTAL_W));
         sqz[c]  = elig[c] && hq[c];
         cand[c] = elig[c] && !hq[c];
      end
   end

   iss_oldest #(.SEQW(SEQW), .WRAP_AGE(WRAP_AGE)) u_oldest (
      .cand  (cand),
      .seq   (hseq),
      .found (found),
      .win   (win)
   );

   always_comb begin
      ptr_o  = ptr_i;
      cnt_o  = cnt_i;
      tot_o  = tot_i;
      fire_o = 1'b0;
      cls_o  = win;
      seq_o  = hseq[win];
      drop_o = sqz;
      if (|sqz) begin
         for (int c = 0; c < NCLS; c++) begin
            if (sqz[c]) ptr_o[c] = ptr_i[c] + PW'(1);
         end
      end else if (found) begin
         ptr_o[win] = ptr_i[win] + PW'(1);
         cnt_o[win] = cnt_i[win] + PW'(1);
         tot_o      = tot_i + CW'(1);
         fire_o     = 1'b1;
      end
   end
endmodule

// File: rtl/iss_stats.sv
// Running issued and squash-discard counters.
module iss_stats
   import iss_pkg::*;
#(
   parameter int unsigned PW  = 2,
   parameter int unsigned SW  = 4,
   parameter int unsigned STW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NCLS-1:0][PW-1:0]  cls_issued,
   input  logic [SW-1:0]            sqz_drop,
   output logic [NCLS-1:0][STW-1:0] stat_issued,
   output logic [STW-1:0]           stat_squash
);
   logic started;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_issued <= '0;
         stat_squash <= '0;
         started     <= 1'b0;
      end else begin
         for (int c = 0; c < NCLS; c++) begin
            stat_issued[c] <= stat_issued[c] + STW'(cls_issued[c]);
         end
         stat_squash <= stat_squash + STW'(sqz_drop);
         started     <= 1'b1;
      end
   end

   // R9: squash counter follows the previous cycle's discards
   a_r9_squash_accum: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (stat_squash == $past(stat_squash) + STW'($past(sqz_drop))));

   // R9: integer counter follows the previous cycle's integer issues
   a_r9_int_accum: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (stat_issued[0] == $past(stat_issued[0]) + STW'($past(cls_issued[0]))));
endmodule

// File: rtl/issue_selector.sv
module issue_selector
   import iss_pkg::*;
#(
   parameter int unsigned SEQW     = 8,
   parameter int unsigned LOOK     = 2,
   parameter int unsigned TOTAL_W  = 4,
   parameter int unsigned CAP_INT  = 2,
   parameter int unsigned CAP_FP   = 2,
   parameter int unsigned CAP_BR   = 1,
   parameter int unsigned CAP_MEM  = 1,
   parameter int unsigned CAP_MISC = 1,
   parameter bit          WRAP_AGE = 1'b1,
   parameter int unsigned STW      = 16,
   localparam int unsigned PW      = $clog2(LOOK + 1),
   localparam int unsigned CW      = $clog2(TOTAL_W + 1),
   localparam int unsigned SW      = $clog2(NCLS * LOOK + 1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NCLS-1:0][LOOK-1:0]           hd_valid,
   input  logic [NCLS-1:0][LOOK-1:0]           hd_squash,
   input  logic [NCLS-1:0][LOOK-1:0][SEQW-1:0] hd_seq,
   output logic [TOTAL_W-1:0]                  iss_valid,
   output logic [TOTAL_W-1:0][CLW-1:0]         iss_class,
   output logic [TOTAL_W-1:0][SEQW-1:0]        iss_seq,
   output logic [CW-1:0]                       iss_count,
   output logic [NCLS-1:0][PW-1:0]             q_pop,
   output logic [NCLS-1:0][PW-1:0]             cls_issued,
   output logic [SW-1:0]                       sqz_drop,
   output logic [NCLS-1:0][STW-1:0]            stat_issued,
   output logic [STW-1:0]                      stat_squash
);
   // every step either issues or drops at least one entry, so this bound always finishes
   localparam int unsigned NSTEP = TOTAL_W + NCLS * LOOK;
   localparam logic [NCLS*8-1:0] CAPV = {8'(CAP_MISC), 8'(CAP_MEM), 8'(CAP_BR),
                                         8'(CAP_FP), 8'(CAP_INT)};

   // elaboration-time parameter checks
   if (LOOK < 1) begin : g_bad_look
      $error("issue_selector: LOOK must be at least 1");
   end
   if (TOTAL_W < 1) begin : g_bad_total
      $error("issue_selector: TOTAL_W must be at least 1");
   end
   if (SEQW < 2) begin : g_bad_seqw
      $error("issue_selector: SEQW must be at least 2");
   end
   if (CAP_INT > LOOK || CAP_FP > LOOK || CAP_BR > LOOK ||
       CAP_MEM > LOOK || CAP_MISC > LOOK) begin : g_bad_cap
      $error("issue_selector: a class cap exceeds the window depth");
   end

   logic [NSTEP-1:0]                fire_s;
   logic [NSTEP-1:0][CLW-1:0]       cls_s;
   logic [NSTEP-1:0][SEQW-1:0]      seq_s;
   logic [NSTEP-1:0][CW-1:0]        slot_s;
   logic [NSTEP-1:0][NCLS-1:0]      drop_s;

   for (genvar s = 0; s < NSTEP; s++) begin : g_step
      logic [NCLS-1:0][PW-1:0] ptr_in, cnt_in, ptr_n, cnt_n;
      logic [CW-1:0]           tot_in, tot_n;

      if (s == 0) begin : g_first
         assign ptr_in = '0;
         assign cnt_in = '0;
         assign tot_in = '0;
      end else begin : g_chain
         assign ptr_in = g_step[s-1].ptr_n;
         assign cnt_in = g_step[s-1].cnt_n;
         assign tot_in = g_step[s-1].tot_n;
      end

      iss_step #(
         .SEQW(SEQW), .LOOK(LOOK), .TOTAL_W(TOTAL_W), .CAPV(CAPV),
         .WRAP_AGE(WRAP_AGE), .PW(PW), .CW(CW)
      ) u_step (
         .hd_valid  (hd_valid),
         .hd_squash (hd_squash),
         .hd_seq    (hd_seq),
         .ptr_i     (ptr_in),
         .cnt_i     (cnt_in),
         .tot_i     (tot_in),
         .ptr_o     (ptr_n),
         .cnt_o     (cnt_n),
         .tot_o     (tot_n),
         .fire_o    (fire_s[s]),
         .cls_o     (cls_s[s]),
         .seq_o     (seq_s[s]),
         .drop_o    (drop_s[s])
      );
      assign slot_s[s] = tot_in;
   end

   assign q_pop      = g_step[NSTEP-1].ptr_n;
   assign cls_issued = g_step[NSTEP-1].cnt_n;
   assign iss_count  = g_step[NSTEP-1].tot_n;

   always_comb begin
      iss_valid = '0;
      iss_class = '0;
      iss_seq   = '0;
      sqz_drop  = '0;
      for (int s = 0; s < NSTEP; s++) begin
         if (fire_s[s]) begin
            iss_valid[slot_s[s]] = 1'b1;
            iss_class[slot_s[s]] = cls_s[s];
            iss_seq[slot_s[s]]   = seq_s[s];
         end
         sqz_drop = sqz_drop + SW'($countones(drop_s[s]));
      end
   end

   iss_stats #(.PW(PW), .SW(SW), .STW(STW)) u_stats (
      .clk         (clk),
      .rst_n       (rst_n),
      .cls_issued  (cls_issued),
      .sqz_drop    (sqz_drop),
      .stat_issued (stat_issued),
      .stat_squash (stat_squash)
   );

   // R2: total width respected and count matches the filled slots
   a_r2_total_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(iss_count) <= int'(TOTAL_W));
   a_r2_count_match: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(iss_valid) == int'(iss_count));

   // R6: nothing valid means nothing issued or popped
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (hd_valid == '0) |-> (iss_count == '0 && q_pop == '0));

   for (genvar c = 0; c < NCLS; c++) begin : g_cls_chk
      // R3: per-class cap
      a_r3_class_cap: assert property (@(posedge clk) disable iff (!rst_n)
         int'(cls_issued[c]) <= int'(CAPV[c*8 +: 8]));
      // R8: pops cover every issued entry of the class
      a_r8_pop_covers: assert property (@(posedge clk) disable iff (!rst_n)
         q_pop[c] >= cls_issued[c]);
   end

   for (genvar k = 0; k + 1 < TOTAL_W; k++) begin : g_slot_chk
      logic [SEQW-1:0] gap;
      assign gap = iss_seq[k] - iss_seq[k+1];
      // R2: slots are filled without holes
      a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[k+1] |-> iss_valid[k]);
      // R11: slot order is oldest to youngest
      a_r11_age_order: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[k+1] |-> (WRAP_AGE ? gap[SEQW-1] : (iss_seq[k] < iss_seq[k+1])));
   end
endmodule

// File: tb/test_issue_selector.sv
`timescale 1ns/1ps
module test_issue_selector;
   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [4:0][1:0]         hd_valid = '0;
   logic [4:0][1:0]         hd_squash = '0;
   logic [4:0][1:0][7:0]    hd_seq = '0;
   logic [3:0]              iss_valid;
   logic [3:0][2:0]         iss_class;
   logic [3:0][7:0]         iss_seq;
   logic [2:0]              iss_count;
   logic [4:0][1:0]         q_pop;
   logic [4:0][1:0]         cls_issued;
   logic [3:0]              sqz_drop;
   logic [4:0][15:0]        stat_issued;
   logic [15:0]             stat_squash;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_stat [5] = '{0, 0, 0, 0, 0};
   int exp_sqz = 0;

   always #5 clk = ~clk;

   issue_selector i_issue_selector (
      .clk(clk), .rst_n(rst_n),
      .hd_valid(hd_valid), .hd_squash(hd_squash), .hd_seq(hd_seq),
      .iss_valid(iss_valid), .iss_class(iss_class), .iss_seq(iss_seq),
      .iss_count(iss_count), .q_pop(q_pop), .cls_issued(cls_issued),
      .sqz_drop(sqz_drop), .stat_issued(stat_issued), .stat_squash(stat_squash)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      hd_valid  = '0;
      hd_squash = '0;
      hd_seq    = '0;
   endtask

   task automatic put(input int c, input int k, input int s, input bit sq);
      hd_valid[c][k]  = 1'b1;
      hd_squash[c][k] = sq;
      hd_seq[c][k]    = 8'(s);
   endtask

   // start a scenario: inputs change just after a falling edge
   task automatic begin_case();
      @(negedge clk);
      clear_in();
   endtask

   // let one rising edge pass with the inputs held, then idle the inputs
   task automatic end_case();
      @(negedge clk);
      clear_in();
   endtask

   task automatic chk_slot(input string req, input int k, input int cls, input int s);
      chk(req, $sformatf("slot%0d valid", k), int'(iss_valid[k]), 1);
      chk(req, $sformatf("slot%0d class", k), int'(iss_class[k]), cls);
      chk(req, $sformatf("slot%0d seq", k), int'(iss_seq[k]), s);
   endtask

   task automatic t_reset();
      begin_case();
      #1;
      chk("R6", "idle count", int'(iss_count), 0);
      chk("R6", "idle pops", int'(q_pop), 0);
      chk("R9", "stat squash after reset", int'(stat_squash), 0);
      chk("R9", "stat int after reset", int'(stat_issued[0]), 0);
      end_case();
   endtask

   // R1 R10 R11 R2: one entry per class, oldest four issue in age order
   task automatic t_oldest();
      begin_case();
      put(0, 0, 10, 0); put(1, 0, 5, 0); put(2, 0, 7, 0);
      put(3, 0, 12, 0); put(4, 0, 3, 0);
      #1;
      chk("R2", "count at total width", int'(iss_count), 4);
      chk_slot("R1", 0, 4, 3);
      chk_slot("R11", 1, 1, 5);
      chk_slot("R10", 2, 2, 7);
      chk_slot("R1", 3, 0, 10);
      chk("R8", "mem left in queue", int'(q_pop[3]), 0);
      chk("R8", "misc popped", int'(q_pop[4]), 1);
      exp_stat[0] += 1; exp_stat[1] += 1; exp_stat[2] += 1; exp_stat[4] += 1;
      end_case();
   endtask

   // R3: memory cap of one stops its second entry; integer takes two
   task automatic t_class_cap();
      begin_case();
      put(0, 0, 1, 0); put(0, 1, 2, 0);
      put(3, 0, 3, 0); put(3, 1, 4, 0);
      #1;
      chk("R3", "count", int'(iss_count), 3);
      chk_slot("R3", 0, 0, 1);
      chk_slot("R3", 1, 0, 2);
      chk_slot("R3", 2, 3, 3);
      chk("R3", "slot3 empty", int'(iss_valid[3]), 0);
      chk("R8", "int issued", int'(cls_issued[0]), 2);
      chk("R8", "mem pop", int'(q_pop[3]), 1);
      exp_stat[0] += 2; exp_stat[3] += 1;
      end_case();
   endtask

   // R4: squashed heads discarded before issuing the survivors
   task automatic t_squash_heads();
      begin_case();
      put(0, 0, 5, 1); put(0, 1, 6, 0);
      put(1, 0, 4, 1); put(1, 1, 9, 0);
      #1;
      chk("R4", "count", int'(iss_count), 2);
      chk_slot("R4", 0, 0, 6);
      chk_slot("R4", 1, 1, 9);
      chk("R4", "drops", int'(sqz_drop), 2);
      chk("R4", "int pop", int'(q_pop[0]), 2);
      chk("R4", "fp pop", int'(q_pop[1]), 2);
      exp_stat[0] += 1; exp_stat[1] += 1; exp_sqz += 2;
      end_case();
   endtask

   // R4: a squashed entry exposed mid-cycle is skipped without a slot hole
   task automatic t_squash_mid();
      begin_case();
      put(0, 0, 1, 0); put(0, 1, 2, 1);
      put(1, 0, 3, 0);
      #1;
      chk("R4", "mid count", int'(iss_count), 2);
      chk_slot("R4", 0, 0, 1);
      chk_slot("R4", 1, 1, 3);
      chk("R4", "mid drops", int'(sqz_drop), 1);
      chk("R8", "mid int pop", int'(q_pop[0]), 2);
      chk("R8", "mid int issued", int'(cls_issued[0]), 1);
      exp_stat[0] += 1; exp_stat[1] += 1; exp_sqz += 1;
      end_case();
   endtask

   // R5: squashed entry behind a capped class stays
   task automatic t_squash_capped();
      begin_case();
      put(2, 0, 1, 0); put(2, 1, 2, 1);
      put(0, 0, 5, 0);
      #1;
      chk("R5", "capped count", int'(iss_count), 2);
      chk("R5", "branch pop", int'(q_pop[2]), 1);
      chk("R5", "capped drops", int'(sqz_drop), 0);
      chk_slot("R5", 0, 2, 1);
      exp_stat[2] += 1; exp_stat[0] += 1;
      end_case();
   endtask

   // R5: squashed entry behind a full cycle stays
   task automatic t_squash_full();
      begin_case();
      put(0, 0, 1, 0); put(0, 1, 2, 0);
      put(1, 0, 3, 0); put(1, 1, 4, 0);
      put(4, 0, 7, 0); put(4, 1, 8, 1);
      #1;
      chk("R5", "full count", int'(iss_count), 4);
      chk("R5", "misc pop", int'(q_pop[4]), 0);
      chk("R5", "full drops", int'(sqz_drop), 0);
      chk_slot("R5", 3, 1, 4);
      exp_stat[0] += 2; exp_stat[1] += 2;
      end_case();
   endtask

   // R6: squash flags on absent entries do nothing
   task automatic t_idle();
      begin_case();
      hd_squash = '1;
      hd_seq[0][0] = 8'd9;
      #1;
      chk("R6", "count", int'(iss_count), 0);
      chk("R6", "valid bits", int'(iss_valid), 0);
      chk("R6", "pops", int'(q_pop), 0);
      chk("R6", "drops", int'(sqz_drop), 0);
      end_case();
   endtask

   // R7: age wraps around
   task automatic t_wrap();
      begin_case();
      put(0, 0, 3, 0); put(1, 0, 250, 0);
      #1;
      chk("R7", "count", int'(iss_count), 2);
      chk_slot("R7", 0, 1, 250);
      chk_slot("R7", 1, 0, 3);
      exp_stat[0] += 1; exp_stat[1] += 1;
      end_case();
   endtask

   task automatic t_stats();
      @(negedge clk);
      for (int c = 0; c < 5; c++) begin
         chk("R9", $sformatf("stat class %0d", c), int'(stat_issued[c]), exp_stat[c]);
      end
      chk("R9", "stat squash", int'(stat_squash), exp_sqz);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_oldest();
      t_class_cap();
      t_squash_heads();
      t_squash_mid();
      t_squash_capped();
      t_squash_full();
      t_idle();
      t_wrap();
      t_stats();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule